// File: doc/BRIEF.md
# Byte-Wide Configuration Fetcher

This block pulls a configuration image out of an external byte-wide memory with no help from a host. Once it is started it drives an address, waits a fixed access time for the memory to answer, captures the byte and then sends that byte bit by bit to a downstream configuration receiver. For every byte it sends, it produces eight serial clock pulses. It makes that serial clock by dividing its own system clock, and no configuration clock comes in from outside.

The image can sit at either end of the address space. A mode input, sampled only when fetching starts, picks one of two directions. Ascending mode starts at address zero and counts up. Descending mode starts at the all-ones address and counts down. This lets the image share a memory with a processor that boots from either end.

While one byte is being sent, the memory is already working on the next address. The block captures the next byte at the falling serial edge that ends the current byte, and it presents the following address on that same edge. The receiver raises a done input when it has taken enough data. The fetcher then parks the serial clock low and freezes the address and the serial data output. It stays parked until reset.

Top module: `bytewide_cfg_fetch`

## Requirements
- R1: While reset is asserted, `mem_addr_o` is 0x0000, `ser_clk_o` is low and `ser_dat_o` is low.
- R2: When `start_i` is sampled high in the idle state with `dir_hi_i` low, `mem_addr_o` becomes 0x0000 on that clock edge. It then increases by one each time a byte is captured.
- R3: When `start_i` is sampled high in the idle state with `dir_hi_i` high, `mem_addr_o` becomes 0xFFFF on that clock edge. It then decreases by one each time a byte is captured.
- R4: The direction is taken from `dir_hi_i` only at the start edge. After that, changes on `dir_hi_i` have no effect, and so does any further `start_i` pulse while fetching.
- R5: The first byte is captured ACC_DLY clock cycles after the first address appears. Each later byte is captured at the falling serial edge that ends the previous byte, which is 16*HALF_CYC cycles after that byte's address appeared. The next address is presented on that same edge, and `mem_addr_o` never changes while `ser_clk_o` is high.
- R6: Each fetched byte yields exactly eight `ser_clk_o` pulses. Each pulse is low for HALF_CYC cycles and high for HALF_CYC cycles, so consecutive rising edges are 2*HALF_CYC cycles apart.
- R7: Bits go out least significant first (bit 0 of the byte first). `ser_dat_o` changes only on the clock edge where `ser_clk_o` falls, and it is stable for the whole high phase.
- R8: One cycle after `done_i` is sampled high, `ser_clk_o` is low. From then on, `mem_addr_o` and `ser_dat_o` hold their values, and `start_i` is ignored until reset, even after `done_i` drops.
- R9: No `ser_clk_o` pulse is produced before a start, or during the wait for the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clock is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin fetching from the selected end of memory |
| dir_hi_i | input | 1 | 0: ascending from 0x0000, 1: descending from 0xFFFF |
| done_i | input | 1 | Receiver has finished; park the fetcher |
| mem_data_i | input | 8 | Data byte returned by the external memory |
| mem_addr_o | output | 16 | Address presented to the external memory |
| ser_clk_o | output | 1 | Serial configuration clock to the receiver |
| ser_dat_o | output | 1 | Serial configuration data, valid on rising `ser_clk_o` |

## Verification
The memory model in the bench returns data for the address seen exactly ACC_DLY cycles earlier. A fetcher that captures a byte one cycle early, or that steps the address before the capture, therefore sends bytes that belong to the wrong address, and the scoreboard sees mismatched bits. Fetches are run in both directions, so a counter that ignores the direction, or that starts from the wrong end, is caught on its very first address. One run changes the direction input and pulses start in the middle of the run; a design that resamples either of them jumps to another address. The bench also raises done both during the first access wait and right after a byte. It checks that the clock does not pulse again, that the address and data stay where they were, and that a later start does not restart the fetch.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HALT  = 2'd3
    } fetch_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } step_dir_e;

endpackage

// File: rtl/cfgf_addr_ctr.sv
module cfgf_addr_ctr
    import cfgf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  step_dir_e         dir_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        step_dir_e         dir;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load_i) begin
            ctr_d.dir  = dir_i;
            ctr_d.addr = (dir_i == DIR_DOWN) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};
        end else if (step_i) begin
            if (ctr_q.dir == DIR_DOWN) begin
                ctr_d.addr = ctr_q.addr - ADDR_W'(1);
            end else begin
                ctr_d.addr = ctr_q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{addr: '0, dir: DIR_UP};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign addr_o = ctr_q.addr;

endmodule

// File: rtl/cfgf_bit_timer.sv
module cfgf_bit_timer #(
    parameter int HALF_CYC = 2,
    parameter int BITS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_o,
    output logic byte_end_o
);

    localparam int HC_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BIT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HALF_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

    typedef struct packed {
        logic [HC_W-1:0]  hc;
        logic             lvl;
        logic [BIT_W-1:0] bitn;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic last_half;

    always_comb begin
        last_half  = (tmr_q.hc == HC_LAST);
        fall_o     = run_i && last_half && tmr_q.lvl;
        byte_end_o = fall_o && (tmr_q.bitn == BIT_LAST);

        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d = '0;
        end else if (last_half) begin
            tmr_d.hc  = '0;
            tmr_d.lvl = !tmr_q.lvl;
            if (tmr_q.lvl) begin
                tmr_d.bitn = byte_end_o ? '0 : tmr_q.bitn + BIT_W'(1);
            end
        end else begin
            tmr_d.hc = tmr_q.hc + HC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign sclk_o = tmr_q.lvl;

endmodule

// File: rtl/cfgf_shifter.sv
module cfgf_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            shift_i,
    input  logic [BITS-1:0] data_i,
    output logic            sdo_o
);

    typedef struct packed {
        logic [BITS-1:0] sh;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load_i) begin
            shf_d.sh = data_i;
        end else if (shift_i) begin
            shf_d.sh = {1'b0, shf_q.sh[BITS-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign sdo_o = shf_q.sh[0];

endmodule

// File: rtl/bytewide_cfg_fetch.sv
module bytewide_cfg_fetch
    import cfgf_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 2,
    parameter int ACC_DLY  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_hi_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              ser_clk_o,
    output logic              ser_dat_o
);

    localparam int PRIME_W = (ACC_DLY > 1) ? $clog2(ACC_DLY) : 1;
    localparam logic [PRIME_W-1:0] PRIME_INIT = PRIME_W'(ACC_DLY - 1);

    typedef struct packed {
        fetch_state_e       st;
        logic [PRIME_W-1:0] wait_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic      addr_load, addr_step;
    logic      sh_load, sh_shift;
    logic      tmr_run, tmr_fall, tmr_byte_end;
    step_dir_e dir_sel;

    assign dir_sel = dir_hi_i ? DIR_DOWN : DIR_UP;
    assign tmr_run = (ctl_q.st == ST_SHIFT) && !done_i;

    always_comb begin
        ctl_d     = ctl_q;
        addr_load = 1'b0;
        addr_step = 1'b0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (done_i) begin
                    ctl_d.st = ST_HALT;
                end else if (start_i) begin
                    addr_load      = 1'b1;
                    ctl_d.st       = ST_PRIME;
                    ctl_d.wait_cnt = PRIME_INIT;
                end
            end
            ST_PRIME: begin
                if (done_i) begin
                    ctl_d.st = ST_HALT;
                end else if (ctl_q.wait_cnt == '0) begin
                    sh_load   = 1'b1;
                    addr_step = 1'b1;
                    ctl_d.st  = ST_SHIFT;
                end else begin
                    ctl_d.wait_cnt = ctl_q.wait_cnt - PRIME_W'(1);
                end
            end
            ST_SHIFT: begin
                if (done_i) begin
                    ctl_d.st = ST_HALT;
                end else if (tmr_byte_end) begin
                    sh_load   = 1'b1;
                    addr_step = 1'b1;
                end else if (tmr_fall) begin
                    sh_shift = 1'b1;
                end
            end
            ST_HALT: begin
                ctl_d = ctl_q;
            end
            default: begin
                ctl_d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, wait_cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cfgf_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (addr_load),
        .dir_i  (dir_sel),
        .step_i (addr_step),
        .addr_o (mem_addr_o)
    );

    cfgf_bit_timer #(
        .HALF_CYC (HALF_CYC),
        .BITS     (DATA_W)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (tmr_run),
        .sclk_o     (ser_clk_o),
        .fall_o     (tmr_fall),
        .byte_end_o (tmr_byte_end)
    );

    cfgf_shifter #(
        .BITS (DATA_W)
    ) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .data_i  (mem_data_i),
        .sdo_o   (ser_dat_o)
    );

endmodule

// File: rtl/cfgf_fetch_chk.sv
module cfgf_fetch_chk #(
    parameter int ADDR_W   = 16,
    parameter int HALF_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_i,
    input logic              ser_clk_o,
    input logic              ser_dat_o,
    input logic [ADDR_W-1:0] mem_addr_o
);

    logic [15:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (!ser_clk_o) begin
            hi_run_q <= '0;
        end else if (hi_run_q != 16'hFFFF) begin
            hi_run_q <= hi_run_q + 16'd1;
        end
    end

    AST_CLK_STOPS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !ser_clk_o); // R8

    AST_ADDR_HELD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> $stable(mem_addr_o)); // R8

    AST_DAT_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_dat_o)); // R7

    AST_ADDR_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_o |-> $stable(mem_addr_o)); // R5

    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_o |-> (hi_run_q < 16'(HALF_CYC))); // R6

endmodule

bind bytewide_cfg_fetch cfgf_fetch_chk #(
    .ADDR_W   (ADDR_W),
    .HALF_CYC (HALF_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done_i),
    .ser_clk_o  (ser_clk_o),
    .ser_dat_o  (ser_dat_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/sim_bytewide_cfg_fetch.sv
module sim_bytewide_cfg_fetch;

    localparam int HALF = 2;
    localparam int ACC  = 3;

    typedef struct packed {
        logic        b;
        logic [15:0] a;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_hi_i = 1'b0;
    logic        done_i = 1'b0;
    logic [7:0]  mem_data_i;
    logic [15:0] mem_addr_o;
    logic        ser_clk_o;
    logic        ser_dat_o;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    logic [15:0] hist [0:ACC-1];

    always #4 clk = ~clk;

    bytewide_cfg_fetch #(
        .ADDR_W   (16),
        .DATA_W   (8),
        .HALF_CYC (HALF),
        .ACC_DLY  (ACC)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dir_hi_i   (dir_hi_i),
        .done_i     (done_i),
        .mem_data_i (mem_data_i),
        .mem_addr_o (mem_addr_o),
        .ser_clk_o  (ser_clk_o),
        .ser_dat_o  (ser_dat_o)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5;
    endfunction

    // memory: returns the byte for the address seen ACC cycles back
    always @(posedge clk) begin
        hist[0] <= mem_addr_o;
        for (int i = 1; i < ACC; i++) hist[i] <= hist[i-1];
    end
    assign mem_data_i = mem_byte(hist[ACC-2]);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor
    logic prev_c = 1'b0;
    logic prev_s = 1'b0;
    bit   armed  = 1'b0;
    int   since  = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_c = 1'b0;
            prev_s = 1'b0;
            armed  = 1'b0;
            since  = 0;
        end else begin
            since = since + 1;
            if (ser_clk_o && !prev_c) begin
                if (armed) chk("R6 rise spacing", since, 2 * HALF);
                since = 0;
                armed = 1'b1;
                if (exp_q.size() == 0) begin
                    chk("R9 unexpected clock pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R7 serial bit", ser_dat_o, e.b);
                    chk("R5 address ahead", mem_addr_o, e.a);
                end
            end
            if (ser_clk_o && prev_c) chk("R7 data steady while high", ser_dat_o, prev_s);
            prev_c = ser_clk_o;
            prev_s = ser_dat_o;
        end
    end

    task automatic do_reset();
        rst_n    = 1'b0;
        start_i  = 1'b0;
        done_i   = 1'b0;
        dir_hi_i = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        chk("R1 addr in reset", mem_addr_o, 16'h0000);
        chk("R1 clk in reset", ser_clk_o, 1'b0);
        chk("R1 data in reset", ser_dat_o, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 no clock before start", ser_clk_o, 1'b0);
    endtask

    task automatic park_and_check();
        logic [15:0] a_hold;
        logic        s_hold;
        done_i = 1'b1;
        @(negedge clk);
        chk("R8 clock low after done", ser_clk_o, 1'b0);
        a_hold = mem_addr_o;
        s_hold = ser_dat_o;
        repeat (30) @(negedge clk);
        chk("R8 address frozen", mem_addr_o, a_hold);
        chk("R8 data frozen", ser_dat_o, s_hold);
        chk("R8 clock parked", ser_clk_o, 1'b0);
        done_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 start ignored after done", mem_addr_o, a_hold);
        chk("R8 no clock after late start", ser_clk_o, 1'b0);
    endtask

    task automatic run_fetch(input bit hi, input int nbytes, input bit disturb);
        logic [15:0] base;
        base = hi ? 16'hFFFF : 16'h0000;
        for (int k = 0; k < nbytes; k++) begin
            logic [15:0] ak;
            logic [15:0] an;
            logic [7:0]  bv;
            ak = hi ? base - 16'(k) : base + 16'(k);
            an = hi ? ak - 16'd1 : ak + 16'd1;
            bv = mem_byte(ak);
            for (int b = 0; b < 8; b++) exp_q.push_back('{b: bv[b], a: an});
        end
        dir_hi_i = hi;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (hi) chk("R3 first address", mem_addr_o, 16'hFFFF);
        else    chk("R2 first address", mem_addr_o, 16'h0000);
        chk("R9 no clock while priming", ser_clk_o, 1'b0);
        if (disturb) begin
            repeat (20) @(negedge clk);
            dir_hi_i = !hi;
            start_i  = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        chk(hi ? "R3 all bytes sent" : "R2 all bytes sent", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state, R2 ascending fetch, R8 park
        do_reset();
        run_fetch(1'b0, 5, 1'b0);
        park_and_check();

        // R3 descending fetch; R4 mode flip and extra start mid-run
        do_reset();
        run_fetch(1'b1, 6, 1'b1);
        park_and_check();

        // R4 ascending with disturbance as well
        do_reset();
        run_fetch(1'b0, 4, 1'b1);
        park_and_check();

        // R8 done while waiting on the first byte
        do_reset();
        dir_hi_i = 1'b1;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        done_i  = 1'b1;
        repeat (40) @(negedge clk);
        chk("R8 address held during prime", mem_addr_o, 16'hFFFF);
        chk("R8 no clock after early done", ser_clk_o, 1'b0);
        done_i = 1'b0;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule